// File: doc/BRIEF.md
# Reed-Solomon Page Parity Engine

This block watches the data bytes of one flash page as they pass on the data path beside it. In generate mode it builds six 10-bit Reed-Solomon parity symbols over the page. Each data byte is inverted, zero-extended to a 10-bit symbol, and shifted into a six-stage division register over GF(2^10). In check mode it runs the same division over the page. It then takes the eight stored parity bytes that follow the page and reports whether the two disagree. Finding and correcting the errors is left to software.

Software drives the engine through a 16-bit register port with byte addresses. A control word starts and stops the engine. Two banks of eight parity bytes hold the results, one plain and one inverted. A check word holds the error flag, and a status word reflects the flash device's ready line. The 60 parity bits are packed little-endian into eight bytes, and each byte is bit-reversed before it is shown. The inverted bank is the one software stores in the spare area. Because the data is inverted before encoding, an erased page of all 0xFF yields an inverted bank of all 0xFF.

Top module: `rs_page_ecc`

## Requirements
- R1: In generate mode, the six parity symbols s0..s5 close the code word. Each data byte d becomes the symbol {2'b00, ~d}, and the first byte has the highest degree. The sequence of data symbols followed by s5, s4, ..., s0 then evaluates to zero at alpha^0 through alpha^5, in GF(2^10) with field polynomial x^10+x^3+1 and alpha = 2.
- R2: A page of 512 bytes of 0xFF, written in generate mode, leaves every byte of the inverted bank at 0x00FF and every byte of the plain bank at 0x0000.
- R3: The packed word is P = {4'b0000, s0, s1, s2, s3, s4, s5}, so s5 occupies bits 9:0. The plain bank word at byte address 0x60+2k shows, in bits 7:0, P[8k+7:8k] with its bit order reversed. Bits 15:8 of the word read 0. The four unused bits of P are 0.
- R4: The inverted bank word at 0x80+2k is the bitwise NOT of the plain bank word at 0x60+2k in bits 7:0, and 0 in bits 15:8.
- R5: The control word is at 0x50. Writing bit 7 as 1 zeroes the parity state, the byte count and the stored parity. Bit 6 selects generate mode and bit 5 enables the byte feed. Reading 0x50 returns bits 6:5 as last written, and bit 7 always reads 0.
- R6: While the feed enable (control bit 5) is 0, strobed bytes leave every result register unchanged.
- R7: In generate mode, only the first 512 strobed bytes after a clear are accepted. Later bytes leave the parity unchanged.
- R8: In check mode, the engine accepts the 512 page bytes and then the 8 stored bytes, in the form read from the inverted bank, in order k = 0..7. Once it has them, check word 0x70 bit 7 is 1 exactly when the stored parity differs from the computed parity. The plain bank then shows the XOR difference, which is all zero for a consistent page.
- R9: The check flag at 0x70 reads 0 until all 520 bytes of a check pass have been accepted.
- R10: The status word at 0x02 returns the device ready input in bit 0 (1 means ready), with 0 in the other bits. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feed_valid | input | 1 | Strobe: a byte is on feed_byte this cycle |
| feed_byte | input | 8 | Observed page or stored-parity byte |
| reg_addr | input | 8 | Register byte address (bit 0 ignored) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| dev_ready | input | 1 | Flash ready/busy line, 1 = ready |

## Verification
The hardest state to reach from the ports is a check pass that holds an error, because the stored parity has to be correct for every byte except a chosen one. The bench first encodes a page and reads back its inverted bank. It then replays that page in check mode, together with the saved bank, once clean, once with one data bit flipped and once with one parity bit flipped. It reads the flag after the seventh stored byte to catch a flag that rises early. The generated parity is never compared with a second encoder. It is judged by evaluating the whole code word at the six generator roots.

// File: rtl/rs_page_ecc.sv
module rs_page_ecc #(
  parameter int DATA_BYTES = 512,
  parameter int SYM_W      = 10,
  parameter int NPAR       = 6,
  parameter logic [SYM_W:0] FIELD_POLY = 11'h409
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        feed_valid,
  input  logic [7:0]  feed_byte,
  input  logic [7:0]  reg_addr,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        dev_ready
);
  localparam int PK_BITS  = SYM_W * NPAR;
  localparam int PK_BYTES = (PK_BITS + 7) / 8;
  localparam int TOTAL    = DATA_BYTES + PK_BYTES;
  localparam int CNT_W    = $clog2(TOTAL + 1);
  localparam logic [6:0] W_STAT = 7'h01, W_CTRL = 7'h28, W_CHK = 7'h38;
  localparam logic [3:0] PG_NORM = 4'h6, PG_INV = 4'h8;

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p, x;
    p = '0; x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p ^= x;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [PK_BITS-1:0] gen_poly();
    logic [SYM_W-1:0] g [NPAR+1];
    logic [SYM_W-1:0] root;
    logic [PK_BITS-1:0] out;
    for (int j = 0; j <= NPAR; j++) g[j] = '0;
    g[0] = 1; root = 1;
    for (int r = 0; r < NPAR; r++) begin
      for (int j = NPAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 2);
    end
    for (int j = 0; j < NPAR; j++) out[j*SYM_W +: SYM_W] = g[j];
    return out;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  localparam logic [PK_BITS-1:0] GEN = gen_poly();

  logic [NPAR-1:0][SYM_W-1:0] par, par_nxt;
  logic [PK_BYTES*8-1:0]      store, pk, result;
  logic [PK_BITS-1:0]         par_flat;
  logic [CNT_W-1:0]           cnt;
  logic                       gen_q, en_q, accept, clr, in_data;
  logic [SYM_W-1:0]           fb;

  assign clr     = reg_we && reg_addr[7:1] == W_CTRL && reg_wdata[7];
  assign in_data = cnt < CNT_W'(DATA_BYTES);
  assign accept  = en_q && feed_valid && (gen_q ? in_data : cnt < CNT_W'(TOTAL));
  assign fb      = {{(SYM_W-8){1'b0}}, ~feed_byte} ^ par[NPAR-1];

  always_comb
    for (int j = 0; j < NPAR; j++)
      par_nxt[j] = (j == 0 ? '0 : par[j-1]) ^ gf_mul(fb, GEN[j*SYM_W +: SYM_W]);

  for (genvar j = 0; j < NPAR; j++) begin : g_pack
    assign par_flat[(NPAR-1-j)*SYM_W +: SYM_W] = par[j];
  end
  assign pk     = {{(PK_BYTES*8-PK_BITS){1'b0}}, par_flat};
  assign result = pk ^ store;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      par <= '0; store <= '0; cnt <= '0; gen_q <= 1'b0; en_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr[7:1] == W_CTRL) begin
        gen_q <= reg_wdata[6];
        en_q  <= reg_wdata[5];
      end
      if (clr) begin
        par <= '0; store <= '0; cnt <= '0;
      end else if (accept) begin
        cnt <= cnt + 1'b1;
        if (in_data) par <= par_nxt;
        else store[(cnt - CNT_W'(DATA_BYTES))*8 +: 8] <= rev8(~feed_byte);
      end
    end

  logic err;
  assign err = !gen_q && cnt == CNT_W'(TOTAL) && |result[PK_BITS-1:0];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[7:1] == W_STAT)      reg_rdata[0] = dev_ready;
    else if (reg_addr[7:1] == W_CTRL) reg_rdata[6:5] = {gen_q, en_q};
    else if (reg_addr[7:1] == W_CHK)  reg_rdata[7] = err;
    else if (reg_addr[7:4] == PG_NORM) reg_rdata[7:0] = rev8(result[reg_addr[3:1]*8 +: 8]);
    else if (reg_addr[7:4] == PG_INV)  reg_rdata[7:0] = ~rev8(result[reg_addr[3:1]*8 +: 8]);
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOTAL));
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (par == '0 && cnt == '0 && store == '0));
  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr) |=> ($stable(par) && $stable(store) && $stable(cnt)));
  p_write_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && cnt == CNT_W'(DATA_BYTES) && !clr) |=> $stable(par));
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/rs_page_ecc_tb.sv
module rs_page_ecc_tb;
  logic clk = 0, rst_n = 0, feed_valid = 0, reg_we = 0, dev_ready = 0;
  logic [7:0] feed_byte = 0, reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  int checks = 0, fails = 0;
  logic [7:0] pg [512];
  logic [7:0] inv [8];
  logic [7:0] nrm [8];
  logic [7:0] saved [8];
  logic [15:0] v;

  always #5 clk = ~clk;

  rs_page_ecc u_dut (.clk, .rst_n, .feed_valid, .feed_byte, .reg_addr, .reg_we,
                     .reg_wdata, .reg_rdata, .dev_ready);

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [9:0] gfm(input logic [9:0] a, input logic [9:0] b);
    logic [18:0] p = '0;
    for (int i = 0; i < 10; i++) if (b[i]) p ^= 19'(a) << i;
    for (int i = 18; i >= 10; i--) if (p[i]) p ^= 19'h409 << (i - 10);
    return p[9:0];
  endfunction

  function automatic logic [7:0] rv(input logic [7:0] x);
    for (int i = 0; i < 8; i++) rv[7-i] = x[i];
  endfunction

  function automatic logic [7:0] pat(input int p, input int n);
    case (p)
      0: return 8'hFF;
      1: return n[7:0];
      2: return 8'h00;
      3: return 8'((n * 37 + 11) ^ (n >> 3));
      default: return (n == 300) ? 8'h5A : 8'hFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk); feed_valid = 1; feed_byte = b;
    @(posedge clk); #1 feed_valid = 0;
  endtask

  task automatic read_banks();
    for (int k = 0; k < 8; k++) begin
      rd(8'h80 + 8'(2*k), v); inv[k] = v[7:0];
      chk(v[15:8] == 0, "R4 inverted bank upper bits", v, {8'h00, v[7:0]});
      rd(8'h60 + 8'(2*k), v); nrm[k] = v[7:0];
      chk(v[15:8] == 0, "R3 plain bank upper bits", v, {8'h00, v[7:0]});
    end
  endtask

  task automatic roots_ok(input int p);
    logic [63:0] pkd;
    logic [9:0] a, acc;
    for (int k = 0; k < 8; k++) pkd[8*k +: 8] = rv(~inv[k]);
    chk(pkd[63:60] == 0, "R3 unused packed bits zero", pkd[63:60], 0);
    a = 10'd1;
    for (int i = 0; i < 6; i++) begin
      acc = '0;
      for (int n = 0; n < 512; n++) acc = gfm(acc, a) ^ {2'b00, ~pg[n]};
      for (int j = 5; j >= 0; j--) acc = gfm(acc, a) ^ pkd[10*(5-j) +: 10];
      chk(acc == 0, $sformatf("R1 root alpha^%0d pattern %0d", i, p), acc, 0);
      a = gfm(a, 10'd2);
    end
  endtask

  task automatic write_page(input int p, input int extra);
    for (int n = 0; n < 512; n++) pg[n] = pat(p, n);
    wr(8'h50, 16'h00E0);
    for (int n = 0; n < 512; n++) feed(pg[n]);
    for (int n = 0; n < extra; n++) feed(8'h3C + 8'(n));
    wr(8'h50, 16'h0000);
    read_banks();
  endtask

  task automatic check_pass(input int flip_data, input int flip_par, input logic [15:0] exp, input string tag);
    wr(8'h50, 16'h00A0);
    for (int n = 0; n < 512; n++) feed(n == flip_data ? pg[n] ^ 8'h01 : pg[n]);
    for (int k = 0; k < 7; k++) feed(k == flip_par ? saved[k] ^ 8'h10 : saved[k]);
    rd(8'h70, v);
    chk(v == 0, {"R9 flag low before last stored byte ", tag}, v, 0);
    feed(7 == flip_par ? saved[7] ^ 8'h10 : saved[7]);
    rd(8'h70, v);
    chk(v == exp, {"R8 check flag ", tag}, v, exp);
    wr(8'h50, 16'h0000);
    rd(8'h70, v);
    chk(v == exp, {"R8 flag held after stop ", tag}, v, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(8'h50, v); chk(v == 0, "R5 control after reset", v, 0);
    rd(8'h70, v); chk(v == 0, "R9 check after reset", v, 0);
    read_banks();
    for (int k = 0; k < 8; k++) begin
      chk(nrm[k] == 8'h00, "R3 plain bank zero after reset", nrm[k], 0);
      chk(inv[k] == 8'hFF, "R4 inverted bank after reset", inv[k], 8'hFF);
    end

    dev_ready = 0; rd(8'h02, v); chk(v == 16'h0000, "R10 status busy", v, 0);
    dev_ready = 1; rd(8'h02, v); chk(v == 16'h0001, "R10 status ready", v, 1);
    rd(8'h40, v); chk(v == 0, "R10 unmapped reads zero", v, 0);

    wr(8'h50, 16'h00E0);
    rd(8'h50, v); chk(v == 16'h0060, "R5 control readback", v, 16'h0060);

    for (int p = 0; p < 5; p++) begin
      write_page(p, (p == 3) ? 5 : 0);
      roots_ok(p);
      for (int k = 0; k < 8; k++)
        chk(nrm[k] == ~inv[k], $sformatf("R4 banks complementary p%0d b%0d", p, k), nrm[k], ~inv[k]);
      if (p == 0)
        for (int k = 0; k < 8; k++) begin
          chk(inv[k] == 8'hFF, "R2 erased page inverted bank", inv[k], 8'hFF);
          chk(nrm[k] == 8'h00, "R2 erased page plain bank", nrm[k], 0);
        end
    end

    for (int k = 0; k < 8; k++) saved[k] = inv[k];
    wr(8'h50, 16'h0040);
    for (int n = 0; n < 20; n++) feed(8'(n * 13));
    wr(8'h50, 16'h0000);
    for (int n = 0; n < 20; n++) feed(8'(n * 7));
    read_banks();
    for (int k = 0; k < 8; k++)
      chk(inv[k] == saved[k], "R6 disabled feed leaves parity", inv[k], saved[k]);

    check_pass(-1, -1, 16'h0000, "clean");
    read_banks();
    for (int k = 0; k < 8; k++)
      chk(nrm[k] == 8'h00, "R8 clean pass difference zero", nrm[k], 0);
    check_pass(100, -1, 16'h0080, "data bit flipped");
    check_pass(-1, 2, 16'h0080, "parity bit flipped");
    check_pass(-1, 7, 16'h0080, "last parity byte flipped");

    wr(8'h50, 16'h0080);
    rd(8'h50, v); chk(v == 0, "R5 clear bit reads zero", v, 0);
    rd(8'h70, v); chk(v == 0, "R5 clear drops check flag", v, 0);
    read_banks();
    for (int k = 0; k < 8; k++) begin
      chk(nrm[k] == 8'h00, "R5 clear zeroes plain bank", nrm[k], 0);
      chk(inv[k] == 8'hFF, "R5 clear sets inverted bank", inv[k], 8'hFF);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule